// File: doc/BRIEF.md
# I2C Register Sequence Loader

This block is a self-starting I2C write master. Once reset is released it walks through a constant table of register writes and sends each entry to one slave device as a separate bus transaction. A typical use is to configure an audio codec at power-up, with no processor involved. SCL and SDA are open-drain: the block either pulls a line low or releases it, and an external pull-up takes it high.

The 7-bit slave address, the number of retries allowed for each entry and the exponent of the bus-rate divider are parameters. The table holds `N_ENTRY` entries of two bytes each, a register byte and a data byte. When the slave does not acknowledge a byte, the block closes the transaction with a STOP and sends the same entry again from its START. When the retries for an entry are used up, it raises a sticky error flag and goes quiet. When every entry has been acknowledged, it raises a sticky done flag and never starts a second pass.

Top module: `i2c_seq_loader`

## Requirements
- R1: While reset is held and right after its release, done and error are low and both lines are released. The first START follows reset release without any other input.
- R2: One SCL period lasts 2^(DIV_LOG2+2) system clocks. It is split into four quarters of 2^DIV_LOG2 clocks, and the lines change only on quarter boundaries.
- R3: Each transaction is a START, then the address byte {DEV_ADDR, 0} sent MSB first (0x34 for the default address 0x1A), then the register byte, then the data byte, then a STOP. Every byte is followed by a ninth clock for the acknowledge.
- R4: Entry i (from 0 to N_ENTRY-1) has register byte 0x10+i and data byte 0x5A XOR (0x13*i mod 256). Entries are sent in ascending order of i.
- R5: An acknowledge is SDA low while SCL is high on the ninth clock. If SDA is high there, the transaction ends with a STOP straight after that clock and no further byte is sent.
- R6: After a NACK, the same entry is sent again from START as long as fewer than RETRY_MAX retries have been used on it. The retry count starts from zero for each new entry.
- R7: A NACK seen with no retry left raises error. Error stays high until reset, both lines stay released, and no START follows.
- R8: Done rises once the last entry has been fully acknowledged. It stays high until reset, both lines stay released, and no second pass starts.
- R9: Done and error are never high at the same time.
- R10: SDA changes while SCL is high only for a START (a fall, outside a transaction) or a STOP (a rise, inside one).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_io | inout | 1 | Open-drain bus clock, driven low or released |
| sda_io | inout | 1 | Open-drain bus data, driven low or released, and sampled for acknowledges |
| done_o | output | 1 | Sticky flag: the whole table has been written |
| error_o | output | 1 | Sticky flag: retries exhausted and the block has stopped |

## Verification
A wrong bit or byte counter shows on the bus within the same transaction. The bench slave then decodes a misplaced acknowledge, a wrong byte value or a wrong byte count at the next STOP, which comes a few hundred clocks later. A wrong entry index or retry counter is caught at the STOP of the affected attempt, because the decoded entry or the number of attempts no longer matches the model. A corrupted end state shows when the flags settle: the wrong flag, a flag that drops, or extra bus traffic during the idle window that follows.

// File: rtl/i2c_ldr_pkg.sv
package i2c_ldr_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_BIT,
    ST_STOP,
    ST_DONE,
    ST_FAIL
  } ldr_state_e;

  // data bytes carried by each table entry (register byte, value byte)
  localparam int BYTES_PER_ENTRY = 2;

  // constant write table, computed from the entry index
  function automatic logic [7:0] entry_byte(input int unsigned idx, input int unsigned pos);
    logic [7:0] i8;
    i8 = idx[7:0];
    if (pos == 0) return 8'h10 + i8;
    return 8'h5A ^ (8'h13 * i8);
  endfunction

endpackage

// File: rtl/i2c_ldr_tick.sv
module i2c_ldr_tick #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // one pulse per bus quarter period
  assign tick_o = &cnt_q;
endmodule

// File: rtl/i2c_ldr_wave.sv
module i2c_ldr_wave
  import i2c_ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ldr_state_e state_i,
  input  logic [1:0] phase_i,
  input  logic       tx_bit_i,
  output logic       scl_low_o,
  output logic       sda_low_o
);
  logic scl_rel, sda_rel;

  always_comb begin
    scl_rel = 1'b1;
    sda_rel = 1'b1;
    unique case (state_i)
      ST_START: begin
        scl_rel = (phase_i != 2'd3);
        sda_rel = (phase_i == 2'd0);
      end
      ST_BIT: begin
        scl_rel = (phase_i == 2'd1) || (phase_i == 2'd2);
        sda_rel = tx_bit_i;
      end
      ST_STOP: begin
        scl_rel = (phase_i != 2'd0);
        sda_rel = phase_i[1];
      end
      default: begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
      end
    endcase
  end

  // registered so that the pads never see a combinational glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      scl_low_o <= ~scl_rel;
      sda_low_o <= ~sda_rel;
    end
  end
endmodule

// File: rtl/i2c_ldr_seq.sv
module i2c_ldr_seq
  import i2c_ldr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h1A,
  parameter int         RETRY_MAX = 0,
  parameter int         N_ENTRY   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       sda_in_i,
  output ldr_state_e state_o,
  output logic [1:0] phase_o,
  output logic       tx_bit_o,
  output logic       done_o,
  output logic       error_o
);
  localparam int ENT_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;
  localparam int RTR_W  = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;
  localparam int BYTE_W = $clog2(BYTES_PER_ENTRY + 1);
  localparam logic [BYTE_W-1:0] LAST_BYTE  = BYTE_W'(BYTES_PER_ENTRY);
  localparam logic [ENT_W-1:0]  LAST_ENTRY = ENT_W'(N_ENTRY - 1);
  localparam logic [RTR_W-1:0]  RTR_LIMIT  = RTR_W'(RETRY_MAX);

  ldr_state_e        state_q, state_d;
  logic [1:0]        phase_q, phase_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [ENT_W-1:0]  entry_q, entry_d;
  logic [RTR_W-1:0]  retry_q, retry_d;
  logic              nack_q, nack_d;
  logic              ackbad_q, ackbad_d;
  logic [7:0]        cur_byte;

  always_comb begin
    if (byte_q == '0) cur_byte = {DEV_ADDR, 1'b0};
    else              cur_byte = entry_byte(int'(entry_q), int'(byte_q) - 1);
  end

  assign tx_bit_o = (bit_q == 4'd8) ? 1'b1 : cur_byte[~bit_q[2:0]];

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    byte_d   = byte_q;
    entry_d  = entry_q;
    retry_d  = retry_q;
    nack_d   = nack_q;
    ackbad_d = ackbad_q;
    if (tick_i) begin
      phase_d = phase_q + 2'd1;
      if (state_q == ST_BIT && phase_q == 2'd2 && bit_q == 4'd8) ackbad_d = sda_in_i;
      if (phase_q == 2'd3) begin
        unique case (state_q)
          ST_START: begin
            state_d = ST_BIT;
            bit_d   = '0;
            byte_d  = '0;
          end
          ST_BIT: begin
            if (bit_q != 4'd8) begin
              bit_d = bit_q + 4'd1;
            end else if (ackbad_q) begin
              nack_d  = 1'b1;
              state_d = ST_STOP;
            end else if (byte_q == LAST_BYTE) begin
              nack_d  = 1'b0;
              state_d = ST_STOP;
            end else begin
              byte_d = byte_q + 1'b1;
              bit_d  = '0;
            end
          end
          ST_STOP: begin
            if (nack_q) begin
              if (retry_q == RTR_LIMIT) begin
                state_d = ST_FAIL;
              end else begin
                retry_d = retry_q + 1'b1;
                state_d = ST_START;
              end
            end else begin
              retry_d = '0;
              if (entry_q == LAST_ENTRY) begin
                state_d = ST_DONE;
              end else begin
                entry_d = entry_q + 1'b1;
                state_d = ST_START;
              end
            end
          end
          default: state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_START;
      phase_q  <= '0;
      bit_q    <= '0;
      byte_q   <= '0;
      entry_q  <= '0;
      retry_q  <= '0;
      nack_q   <= 1'b0;
      ackbad_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      byte_q   <= byte_d;
      entry_q  <= entry_d;
      retry_q  <= retry_d;
      nack_q   <= nack_d;
      ackbad_q <= ackbad_d;
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
  assign done_o  = (state_q == ST_DONE);
  assign error_o = (state_q == ST_FAIL);
endmodule

// File: rtl/i2c_seq_loader.sv
module i2c_seq_loader
  import i2c_ldr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h1A,
  parameter int         RETRY_MAX = 0,
  parameter int         DIV_LOG2  = 6,
  parameter int         N_ENTRY   = 4
) (
  input  logic clk,
  input  logic rst_n,
  inout  wire  scl_io,
  inout  wire  sda_io,
  output logic done_o,
  output logic error_o
);
  logic [1:0] rst_pipe_q;
  logic [1:0] sda_pipe_q;
  logic       rst_sync_n;
  logic       tick;
  logic       scl_low, sda_low;
  logic       tx_bit;
  logic [1:0] phase;
  ldr_state_e state;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // SDA input synchroniser
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sda_pipe_q <= 2'b11;
    else             sda_pipe_q <= {sda_pipe_q[0], sda_io};
  end

  i2c_ldr_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  i2c_ldr_seq #(
    .DEV_ADDR  (DEV_ADDR),
    .RETRY_MAX (RETRY_MAX),
    .N_ENTRY   (N_ENTRY)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick),
    .sda_in_i (sda_pipe_q[1]),
    .state_o  (state),
    .phase_o  (phase),
    .tx_bit_o (tx_bit),
    .done_o   (done_o),
    .error_o  (error_o)
  );

  i2c_ldr_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .state_i   (state),
    .phase_i   (phase),
    .tx_bit_i  (tx_bit),
    .scl_low_o (scl_low),
    .sda_low_o (sda_low)
  );

  assign scl_io = scl_low ? 1'b0 : 1'bz;
  assign sda_io = sda_low ? 1'b0 : 1'bz;
endmodule

// File: rtl/i2c_ldr_chk.sv
module i2c_ldr_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic scl_low,
  input logic sda_low,
  input logic done,
  input logic error
);
  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R7
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  // R7
  lines_free_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!scl_low && !sda_low));

  // R2
  scl_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_low) |-> $past(tick, 2));

  // R2
  sda_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> $past(tick, 2));
endmodule

bind i2c_seq_loader i2c_ldr_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick    (tick),
  .scl_low (scl_low),
  .sda_low (sda_low),
  .done    (done_o),
  .error   (error_o)
);

// File: tb/i2c_seq_loader_bench.sv
`timescale 1ns/1ps
module i2c_seq_loader_bench;
  localparam int RMAX = 2;
  localparam int NENT = 4;
  localparam int DLOG = 2;
  localparam int BIT_NS = 10 * (1 << (DLOG + 2));

  logic clk;
  logic rst_n;
  logic slave_low;
  wire  scl_w, sda_w;
  logic done_o, error_o;

  pullup (scl_w);
  pullup (sda_w);
  assign sda_w = slave_low ? 1'b0 : 1'bz;

  i2c_seq_loader #(
    .RETRY_MAX (RMAX),
    .DIV_LOG2  (DLOG),
    .N_ENTRY   (NENT)
  ) u_i2c_seq_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_io  (scl_w),
    .sda_io  (sda_w),
    .done_o  (done_o),
    .error_o (error_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nack_pos [64];
  int att, bitcnt, bytecnt, illegal;
  int m_entry, m_tries;
  bit m_end, m_err, in_tx;
  logic [7:0] shreg;
  logic [7:0] rx [3];
  realtime last_rise;

  function automatic logic [7:0] exp_reg(int i);
    return 8'(8'h10 + i);
  endfunction
  function automatic logic [7:0] exp_dat(int i);
    logic [7:0] p;
    p = 8'(8'h13 * i);
    return 8'h5A ^ p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // bench slave and bus monitor
  task automatic finish_attempt();
    bit exp_nack;
    int exp_bytes;
    exp_nack  = nack_pos[att] < 3;
    exp_bytes = exp_nack ? nack_pos[att] + 1 : 3;
    chk(!m_end, "R8 no transaction after end", att, 0);
    chk(rx[0] == 8'h34, "R3 address byte", rx[0], 8'h34);
    chk(bytecnt == exp_bytes, "R5 byte count", bytecnt, exp_bytes);
    if (bytecnt >= 2) chk(rx[1] == exp_reg(m_entry), "R4 register byte", rx[1], exp_reg(m_entry));
    if (bytecnt >= 3) chk(rx[2] == exp_dat(m_entry), "R4 data byte", rx[2], exp_dat(m_entry));
    if (exp_nack) begin
      if (m_tries == RMAX) begin m_end = 1; m_err = 1; end
      else m_tries++;
    end else begin
      m_tries = 0;
      m_entry++;
      if (m_entry == NENT) begin m_end = 1; m_err = 0; end
    end
    att++;
  endtask

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    if (in_tx) illegal++;
    in_tx = 1; bitcnt = -1; bytecnt = 0; slave_low = 0;
  end

  always @(posedge sda_w) if (scl_w === 1'b1) begin
    if (!in_tx) illegal++;
    else finish_attempt();
    in_tx = 0;
  end

  always @(posedge scl_w) if (in_tx) begin
    if (bitcnt >= 0 && bitcnt < 8) begin
      shreg = {shreg[6:0], sda_w};
      if (bytecnt == 0 && bitcnt == 1)
        chk(($realtime - last_rise) == BIT_NS, "R2 SCL period", int'($realtime - last_rise), BIT_NS);
    end
    last_rise = $realtime;
  end

  always @(negedge scl_w) if (in_tx) begin
    bitcnt++;
    if (bitcnt == 8) begin
      if (bytecnt < 3) rx[bytecnt] = shreg;
      slave_low = (nack_pos[att] != bytecnt);
    end else if (bitcnt == 9) begin
      slave_low = 0;
      bitcnt = 0;
      bytecnt++;
    end
  end

  task automatic run_case(input string name);
    int t;
    int att_end;
    bit d0, e0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!done_o && !error_o, "R1 flags in reset", {done_o, error_o}, 0);
    chk(scl_w === 1'b1 && sda_w === 1'b1, "R1 lines released in reset", {scl_w, sda_w}, 3);
    att = 0; m_entry = 0; m_tries = 0; m_end = 0; m_err = 0;
    in_tx = 0; slave_low = 0; bitcnt = 0; bytecnt = 0; illegal = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done_o && !error_o, "R1 flags after release", {done_o, error_o}, 0);
    t = 0;
    while (!(done_o || error_o) && t < 30000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 30000, {"R1 sequence ends: ", name}, t, 30000);
    repeat (8) @(negedge clk);
    chk(m_end, {"R6 model reached end: ", name}, m_end, 1);
    chk(error_o == m_err, {"R7 error flag: ", name}, error_o, m_err);
    chk(done_o == !m_err, {"R8 done flag: ", name}, done_o, !m_err);
    chk(!(done_o && error_o), "R9 flags exclusive", {done_o, error_o}, 0);
    d0 = done_o; e0 = error_o; att_end = att;
    repeat (800) @(negedge clk);
    chk(att == att_end, "R8 no second pass", att, att_end);
    chk(done_o == d0 && error_o == e0, "R7 flags sticky", {done_o, error_o}, {d0, e0});
    chk(scl_w === 1'b1 && sda_w === 1'b1, "R7 lines idle at end", {scl_w, sda_w}, 3);
    chk(illegal == 0, "R10 SDA edges while SCL high", illegal, 0);
  endtask

  task automatic plan_clear();
    for (int k = 0; k < 64; k++) nack_pos[k] = 3;
  endtask

  initial begin
    rst_n = 1'b0;
    slave_low = 1'b0;
    void'($urandom(32'd2024));
    // all acknowledged
    plan_clear();
    run_case("all ack");
    // R6: two address NACKs on entry 0, then success
    plan_clear();
    nack_pos[0] = 0; nack_pos[1] = 0;
    run_case("retry on address");
    // R6: every entry spends its full retry budget, then succeeds
    plan_clear();
    for (int e = 0; e < NENT; e++) begin
      nack_pos[3*e] = e % 3; nack_pos[3*e+1] = (e + 1) % 3;
    end
    run_case("retry reset per entry");
    // R7: register byte refused three times on entry 0
    plan_clear();
    nack_pos[0] = 1; nack_pos[1] = 1; nack_pos[2] = 1;
    run_case("fail on first entry");
    // R7: data byte of last entry refused three times
    plan_clear();
    nack_pos[3] = 2; nack_pos[4] = 2; nack_pos[5] = 2;
    run_case("fail on last entry");
    // R5 R6 random NACK patterns
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 64; k++)
        nack_pos[k] = ($urandom_range(9) < 3) ? int'($urandom_range(2)) : 3;
      run_case("random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule